// File: doc/BRIEF.md
# Pulse-Width On-Off-Keyed Frame Transmitter

This block sends a short control frame on a single on-off-keyed data line. A send strobe captures a 4-bit button bitmap and builds a 40-bit frame. The frame holds a gain-settling training byte, a sync byte, a device address, the button byte and an XOR checksum. Each bit goes out as a high pulse followed by a fixed low gap. The width of the high pulse carries the bit value.

All timing is counted in cycles of a tick enable, where one tick stands for 1 µs. The defaults are 500 ticks high for a zero, 1000 ticks high for a one, and a 500-tick gap after either. Whenever no frame is in flight, the data line rests low so that the carrier is off. A busy flag covers the whole frame, and a strobe that arrives during a frame is dropped.

Top module: `ookt_tx`

## Requirements
- R1: After reset and whenever busy is low, `rf_data` is 0 and stays 0.
- R2: An accepted frame is 40 bits sent most-significant bit first, in this byte order: 0x55, 0xAA, the device address (default 0x42), the button byte, the checksum byte.
- R3: In the button byte, bit 0 carries `buttons[0]` (button 1) through bit 3 for `buttons[3]` (button 4), and bits 7..4 are 0.
- R4: The checksum byte equals 0xAA XOR address XOR button byte.
- R5: A 0 bit is `rf_data` high for exactly ZERO_HIGH_TICKS ticks, then low for exactly GAP_TICKS ticks.
- R6: A 1 bit is `rf_data` high for exactly ONE_HIGH_TICKS ticks, then low for exactly GAP_TICKS ticks.
- R7: A strobe with busy low is accepted at that clock edge. From the next cycle, `busy` and `rf_data` are both 1. `busy` falls at the edge that consumes the last gap tick of bit 39, with `rf_data` already low.
- R8: A strobe while busy is ignored. The running frame continues unchanged and no further frame follows it.
- R9: The bitmap is latched on acceptance, so `buttons` changes during a frame do not alter it.
- R10: In cycles without `tick_en`, `rf_data` and `busy` do not change, except at an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per 1 µs timing tick |
| send | input | 1 | Frame send strobe |
| buttons | input | 4 | Button bitmap, bit 0 is button 1 |
| rf_data | output | 1 | On-off-keyed data line to the modulator |
| busy | output | 1 | High while a frame is in flight |

## Verification
The bench decodes the line by counting ticks in each high and low stretch. A pulse that is off by one tick shows up as a symbol mismatch, and so does a gap that varies with the bit value. Reassembling the 40 bits exposes a swapped byte, a least-significant-first order, a button byte with stray upper bits, or a checksum that leaves out a term. A mid-frame strobe carrying a different bitmap catches a design that restarts or appends a frame, or that re-reads `buttons`. A pause in the ticks catches timing that runs on the clock and not on the enable.

// File: rtl/ookt_pkg.sv
package ookt_pkg;
    localparam logic [7:0] TRAIN_BYTE = 8'h55;
    localparam logic [7:0] SYNC_BYTE  = 8'hAA;
    localparam int FRAME_BYTES = 5;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;

    typedef struct packed {
        logic [7:0] train;
        logic [7:0] sync;
        logic [7:0] addr;
        logic [7:0] btn;
        logic [7:0] chk;
    } frame_t;

    typedef enum logic {PH_HIGH = 1'b0, PH_GAP = 1'b1} phase_t;

    function automatic frame_t make_frame(input logic [7:0] addr, input logic [3:0] b);
        frame_t f;
        f.train = TRAIN_BYTE;
        f.sync  = SYNC_BYTE;
        f.addr  = addr;
        f.btn   = {4'b0000, b};
        f.chk   = SYNC_BYTE ^ addr ^ {4'b0000, b};
        return f;
    endfunction
endpackage

// File: rtl/ookt_frame.sv
module ookt_frame
    import ookt_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h42
) (
    input  logic [3:0] buttons,
    output frame_t     frame
);
    always_comb frame = make_frame(DEV_ADDR, buttons);
endmodule

// File: rtl/ookt_symbol.sv
module ookt_symbol
    import ookt_pkg::*;
#(
    parameter int ZERO_HIGH_TICKS = 500,
    parameter int ONE_HIGH_TICKS  = 1000,
    parameter int GAP_TICKS       = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic load,
    input  logic bit_val,
    output logic active,
    output logic line,
    output logic done
);
    localparam int MAX_TICKS = (ONE_HIGH_TICKS > GAP_TICKS) ?
        ((ONE_HIGH_TICKS > ZERO_HIGH_TICKS) ? ONE_HIGH_TICKS : ZERO_HIGH_TICKS) :
        ((GAP_TICKS > ZERO_HIGH_TICKS) ? GAP_TICKS : ZERO_HIGH_TICKS);
    localparam int CW = $clog2(MAX_TICKS + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          last_tick;

    assign last_tick = active && tick_en && (cnt == CW'(1));
    assign done      = last_tick && (phase == PH_GAP);
    assign line      = active && (phase == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= PH_HIGH;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            phase  <= PH_HIGH;
            cnt    <= bit_val ? CW'(ONE_HIGH_TICKS) : CW'(ZERO_HIGH_TICKS);
        end else if (active && tick_en) begin
            if (cnt == CW'(1)) begin
                if (phase == PH_HIGH) begin
                    phase <= PH_GAP;
                    cnt   <= CW'(GAP_TICKS);
                end else begin
                    active <= 1'b0;
                end
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAX_TICKS));                                             // R5
    AST_GAP_FIXED: assert property (@(posedge clk) disable iff (rst)
        (last_tick && phase == PH_HIGH && !load) |=> (!line && cnt == CW'(GAP_TICKS))); // R6
endmodule

// File: rtl/ookt_tx.sv
module ookt_tx
    import ookt_pkg::*;
#(
    parameter int         ZERO_HIGH_TICKS = 500,
    parameter int         ONE_HIGH_TICKS  = 1000,
    parameter int         GAP_TICKS       = 500,
    parameter logic [7:0] DEV_ADDR        = 8'h42
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       send,
    input  logic [3:0] buttons,
    output logic       rf_data,
    output logic       busy
);
    localparam int IW = $clog2(FRAME_BITS);

    frame_t                fr_new;
    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         left;
    logic                  accept, sym_done, load, bit_val;

    ookt_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
        .buttons (buttons),
        .frame   (fr_new)
    );

    assign accept  = send && !busy;
    assign load    = accept || (sym_done && left != '0);
    assign bit_val = accept ? fr_new[FRAME_BITS-1] : shreg[FRAME_BITS-2];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
        end else if (accept) begin
            shreg <= fr_new;
            left  <= IW'(FRAME_BITS - 1);
        end else if (sym_done && left != '0) begin
            shreg <= shreg << 1;
            left  <= left - IW'(1);
        end
    end

    ookt_symbol #(
        .ZERO_HIGH_TICKS (ZERO_HIGH_TICKS),
        .ONE_HIGH_TICKS  (ONE_HIGH_TICKS),
        .GAP_TICKS       (GAP_TICKS)
    ) u_sym (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .load    (load),
        .bit_val (bit_val),
        .active  (busy),
        .line    (rf_data),
        .done    (sym_done)
    );

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rf_data);                                                // R1
    AST_CHECKSUM: assert property (@(posedge clk) disable iff (rst)
        accept |=> (shreg[7:0] == (shreg[31:24] ^ shreg[23:16] ^ shreg[15:8]))); // R4
    AST_BUSY_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!rf_data && !$past(rf_data)));                     // R7
    AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && send && !sym_done) |=> $stable(shreg));                    // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !accept) |=> ($stable(rf_data) && $stable(busy)));     // R10
endmodule

// File: tb/sim_ookt_tx.sv
module sim_ookt_tx;
    localparam int ZH = 4, OH = 8, GP = 3;

    logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, send = 1'b0;
    logic [3:0] buttons = 4'h0;
    logic rf_data, busy;
    logic tick_run = 1'b1;

    int checks = 0, fails = 0;
    logic       exp_bits[$];
    logic [39:0] exp_frames[$];

    always #4 clk = ~clk;

    ookt_tx #(.ZERO_HIGH_TICKS(ZH), .ONE_HIGH_TICKS(OH), .GAP_TICKS(GP)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .send(send),
        .buttons(buttons), .rf_data(rf_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] model_frame(input logic [3:0] b);
        logic [7:0] bb = {4'b0000, b};
        return {8'h55, 8'hAA, 8'h42, bb, 8'hAA ^ 8'h42 ^ bb};
    endfunction

    // tick: one cycle in three
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == 2) ? 0 : div + 1;
            tick_en = tick_run && (div == 0);
        end
    end

    // monitor: decode symbols and compare with the scoreboard
    initial begin
        logic prev_rf = 0, prev_busy = 0, in_sym = 0;
        int hcnt = 0, lcnt = 0, nbits = 0;
        logic [39:0] acc = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if ((rf_data && !prev_rf) || (!busy && prev_busy)) begin
                    if (in_sym) begin
                        logic eb;
                        int eh;
                        eb = (exp_bits.size() > 0) ? exp_bits.pop_front() : 1'b0;
                        eh = eb ? OH : ZH;
                        chk(hcnt == eh, eb ? "R6 high width" : "R5 high width", hcnt, eh);
                        chk(lcnt == GP, eb ? "R6 gap width" : "R5 gap width", lcnt, GP);
                        acc = {acc[38:0], (hcnt == OH)};
                        nbits++;
                    end
                    in_sym = rf_data;
                    hcnt = 0; lcnt = 0;
                end
                if (!busy && prev_busy) begin
                    logic [39:0] ef;
                    ef = (exp_frames.size() > 0) ? exp_frames.pop_front() : '0;
                    chk(nbits == 40, "R2 bit count", nbits, 40);
                    chk(acc == ef, "R2 frame order", int'(acc[31:0]), int'(ef[31:0]));
                    chk(acc[15:8] == ef[15:8], "R3 button byte", acc[15:8], ef[15:8]);
                    chk(acc[7:0] == ef[7:0], "R4 checksum", acc[7:0], ef[7:0]);
                    chk(!rf_data, "R7 line low at end", rf_data, 0);
                    nbits = 0; acc = '0;
                end
                if (tick_en && busy) begin
                    if (rf_data) hcnt++; else lcnt++;
                end
            end
            prev_rf = rf_data;
            prev_busy = busy;
        end
    end

    task automatic start_frame(input logic [3:0] b);
        logic [39:0] f = model_frame(b);
        @(negedge clk);
        buttons = b;
        send = 1'b1;
        for (int i = 39; i >= 0; i--) exp_bits.push_back(f[i]);
        exp_frames.push_back(f);
        @(posedge clk);
        @(negedge clk);
        send = 1'b0;
        chk(busy && rf_data, "R7 start", {busy, rf_data}, 3);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rf_data && !busy, "R1 reset state", {busy, rf_data}, 0);

        start_frame(4'h0); wait_idle();
        start_frame(4'hF); wait_idle();
        start_frame(4'h5); wait_idle();
        start_frame(4'hA); wait_idle();

        // R8/R9/R10: strobe and bitmap change mid-frame, ticks paused
        start_frame(4'h3);
        repeat (60) @(negedge clk);
        buttons = 4'hC;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        begin
            logic rf0, b0;
            tick_run = 1'b0;
            @(negedge clk);
            rf0 = rf_data; b0 = busy;
            repeat (40) begin
                @(negedge clk);
                chk(rf_data == rf0 && busy == b0, "R10 hold without tick",
                    {busy, rf_data}, {b0, rf0});
            end
            tick_run = 1'b1;
        end
        wait_idle();
        repeat (40) begin
            @(negedge clk);
            chk(!busy && !rf_data, "R8 no extra frame / R1 idle low", {busy, rf_data}, 0);
        end
        chk(exp_bits.size() == 0, "R9 scoreboard drained", exp_bits.size(), 0);

        start_frame(4'h1); wait_idle();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule